// File: doc/BRIEF.md
# USB Endpoint Handshake Selector

This block chooses the handshake that a USB device function answers with for every token the host sends to one of its endpoints. Each decoded token (SETUP, IN or OUT, with an endpoint number) enters on a valid/ready stream. One handshake choice (none, ACK, NAK or STALL) leaves per accepted token on a second valid/ready stream, and the packet-level logic consumes it there.

Two stall mechanisms are tracked apart because they clear differently. Each non-control endpoint has a halt bit that firmware commands set and clear. While the bit is set, that endpoint answers STALL to data tokens until an explicit clear command arrives. The default control pipe, endpoint 0, has a protocol-stall flag. The flag is raised when the request decoder reports an unsupported request, and the next SETUP on endpoint 0 drops it automatically. A SETUP is always acknowledged, so the control pipe stays usable after any stall. Bus reset clears both kinds.

Back-pressure rules: a token is accepted on a clock edge where `tok_valid` and `tok_ready` are both high. `tok_ready` is high whenever the output slot is empty or is being drained in the same cycle. A handshake choice stays on `hs_code` with `hs_valid` high until `hs_ready` takes it.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: After reset `hs_valid` is 0, `tok_ready` is 1, no endpoint is halted and the protocol stall is clear.
- R2: A SETUP token (`tok_pid`=0) yields ACK (`hs_code`=1) on any endpoint, whatever the stall state.
- R3: Accepting a SETUP on endpoint 0 clears the protocol stall. A `req_done` pulse with `req_supported`=0 sets it. When both happen on the same edge, the flag ends up set.
- R4: While the protocol stall is set, IN (`tok_pid`=1) and OUT (`tok_pid`=2) tokens on endpoint 0 yield STALL (`hs_code`=3).
- R5: A halt command (`halt_cmd_valid`=1, `halt_cmd_set`=1) to endpoint 1..NUM_EP-1 makes IN and OUT on that endpoint yield STALL. A command with `halt_cmd_set`=0 to that endpoint ends this.
- R6: Halt commands addressed to endpoint 0 have no effect.
- R7: A `bus_reset` pulse clears every halt bit and the protocol stall.
- R8: IN on an endpoint that is not stalled yields none (`hs_code`=0, data is sent instead) when its `in_data_ready` bit is 1. Otherwise it yields NAK (`hs_code`=2).
- R9: OUT on an endpoint that is not stalled yields ACK when its `out_buf_free` bit is 1. Otherwise it yields NAK.
- R10: The reserved token code `tok_pid`=3 yields none.
- R11: `tok_ready` equals `!hs_valid || hs_ready`. While `hs_valid` is 1 and `hs_ready` is 0, `hs_valid` and `hs_code` hold.
- R12: The choice for a token accepted at an edge appears with `hs_valid` right after that edge. It is based on the stall state before that edge, so commands on the same edge affect only later tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset pulse, clears all stalls |
| tok_valid | input | 1 | Token stream valid |
| tok_ready | output | 1 | Token stream ready |
| tok_pid | input | 2 | Token kind: 0 SETUP, 1 IN, 2 OUT, 3 reserved |
| tok_ep | input | EPW | Endpoint number of the token |
| req_done | input | 1 | Request decoder finished evaluating a SETUP request |
| req_supported | input | 1 | Request was supported (valid with req_done) |
| halt_cmd_valid | input | 1 | One-cycle halt command strobe |
| halt_cmd_set | input | 1 | 1 sets the halt bit, 0 clears it |
| halt_cmd_ep | input | EPW | Endpoint the halt command addresses |
| in_data_ready | input | NUM_EP | Per-endpoint IN data available |
| out_buf_free | input | NUM_EP | Per-endpoint OUT buffer free |
| hs_valid | output | 1 | Handshake choice valid |
| hs_ready | input | 1 | Handshake consumer ready |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |

## Verification
The assertions assume that the halt command and request report are single-cycle strobes sampled only on clock edges. They also assume that `tok_pid`, `tok_ep` and the status vectors are stable while `tok_valid` waits for `tok_ready`, and that bus reset may coincide with any other input. The stimulus drives every input once per cycle away from the rising edge. It applies commands, request reports and bus resets on the same edges as accepted tokens, to cover the ordering corners. Consumer readiness is randomised so the output slot is often held under back-pressure.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

  typedef enum logic [1:0] {
    PID_SETUP = 2'd0,
    PID_IN    = 2'd1,
    PID_OUT   = 2'd2,
    PID_RSV   = 2'd3
  } tok_kind_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_kind_e;

endpackage

// File: rtl/ep_halt_bank.sv
module ep_halt_bank #(
  parameter int NUM_EP = 8,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              cmd_valid,
  input  logic              cmd_set,
  input  logic [EPW-1:0]    cmd_ep,
  output logic [NUM_EP-1:0] halted
);

  // Endpoint 0 carries no halt bit: the control pipe must stay usable.
  assign halted[0] = 1'b0;

  for (genvar i = 1; i < NUM_EP; i++) begin : g_ep
    logic hit;
    assign hit = cmd_valid && (cmd_ep == EPW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         halted[i] <= 1'b0;
      else if (bus_reset) halted[i] <= 1'b0;
      else if (hit)       halted[i] <= cmd_set;
    end
  end

  p_set_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_set && cmd_ep != '0 && !bus_reset) |=> halted[$past(cmd_ep)]);

  p_busreset_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (halted == '0));

endmodule

// File: rtl/ep_proto_stall.sv
module ep_proto_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic setup0_fire,
  input  logic req_done,
  input  logic req_supported,
  output logic pstall
);

  logic pstall_n;

  // A new SETUP clears first; the report for that request is then applied.
  always_comb begin
    pstall_n = pstall;
    if (setup0_fire)                 pstall_n = 1'b0;
    if (req_done && !req_supported)  pstall_n = 1'b1;
    if (bus_reset)                   pstall_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pstall <= 1'b0;
    else        pstall <= pstall_n;
  end

  p_setup_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (setup0_fire && !(req_done && !req_supported)) |=> !pstall);

  p_unsupported_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && !req_supported && !bus_reset) |=> pstall);

endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic [1:0]        pid,
  input  logic [EPW-1:0]    ep,
  input  logic [NUM_EP-1:0] halted,
  input  logic              pstall,
  input  logic [NUM_EP-1:0] in_rdy,
  input  logic [NUM_EP-1:0] out_free,
  output logic [1:0]        code
);

  logic stalled;
  assign stalled = halted[ep] || ((ep == '0) && pstall);

  always_comb begin
    code = HS_NONE;
    unique case (pid)
      PID_SETUP: code = HS_ACK;
      PID_IN:    code = stalled ? HS_STALL : (in_rdy[ep] ? HS_NONE : HS_NAK);
      PID_OUT:   code = stalled ? HS_STALL : (out_free[ep] ? HS_ACK : HS_NAK);
      default:   code = HS_NONE;
    endcase
  end

endmodule

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [1:0]        tok_pid,
  input  logic [EPW-1:0]    tok_ep,
  input  logic              req_done,
  input  logic              req_supported,
  input  logic              halt_cmd_valid,
  input  logic              halt_cmd_set,
  input  logic [EPW-1:0]    halt_cmd_ep,
  input  logic [NUM_EP-1:0] in_data_ready,
  input  logic [NUM_EP-1:0] out_buf_free,
  output logic              hs_valid,
  input  logic              hs_ready,
  output logic [1:0]        hs_code
);

  logic [NUM_EP-1:0] halted;
  logic              pstall;
  logic              tok_fire;
  logic              setup0_fire;
  logic [1:0]        choice;
  logic              slot_q;
  logic [1:0]        code_q;

  assign tok_ready   = !slot_q || hs_ready;
  assign tok_fire    = tok_valid && tok_ready;
  assign setup0_fire = tok_fire && (tok_pid == PID_SETUP) && (tok_ep == '0);

  ep_halt_bank #(.NUM_EP(NUM_EP)) u_halt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .cmd_valid (halt_cmd_valid),
    .cmd_set   (halt_cmd_set),
    .cmd_ep    (halt_cmd_ep),
    .halted    (halted)
  );

  ep_proto_stall u_pstall (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_reset     (bus_reset),
    .setup0_fire   (setup0_fire),
    .req_done      (req_done),
    .req_supported (req_supported),
    .pstall        (pstall)
  );

  ep_hs_decide #(.NUM_EP(NUM_EP)) u_decide (
    .pid      (tok_pid),
    .ep       (tok_ep),
    .halted   (halted),
    .pstall   (pstall),
    .in_rdy   (in_data_ready),
    .out_free (out_buf_free),
    .code     (choice)
  );

  // One-entry output slot: refilled on the same edge it drains.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
      code_q <= HS_NONE;
    end else if (tok_fire) begin
      slot_q <= 1'b1;
      code_q <= choice;
    end else if (hs_ready) begin
      slot_q <= 1'b0;
    end
  end

  assign hs_valid = slot_q;
  assign hs_code  = code_q;

  p_hold_under_backpressure_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !hs_ready) |=> (hs_valid && $stable(hs_code)));

  p_setup_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_fire && tok_pid == PID_SETUP) |=> (hs_valid && hs_code == HS_ACK));

  p_protocol_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_fire && (tok_pid == PID_IN || tok_pid == PID_OUT) && tok_ep == '0 && pstall)
      |=> (hs_code == HS_STALL));

  p_reserved_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_fire && tok_pid == PID_RSV) |=> (hs_valid && hs_code == HS_NONE));

endmodule

// File: tb/ep_handshake_ctrl_bench.sv
module ep_handshake_ctrl_bench;

  localparam int NUM_EP = 8;
  localparam int EPW = $clog2(NUM_EP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic tok_valid = 1'b0;
  logic tok_ready;
  logic [1:0] tok_pid = '0;
  logic [EPW-1:0] tok_ep = '0;
  logic req_done = 1'b0, req_supported = 1'b0;
  logic halt_cmd_valid = 1'b0, halt_cmd_set = 1'b0;
  logic [EPW-1:0] halt_cmd_ep = '0;
  logic [NUM_EP-1:0] in_data_ready = '0, out_buf_free = '0;
  logic hs_valid;
  logic hs_ready = 1'b1;
  logic [1:0] hs_code;

  always #5 clk = ~clk;

  ep_handshake_ctrl #(.NUM_EP(NUM_EP)) u_ep_handshake_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_pid(tok_pid), .tok_ep(tok_ep),
    .req_done(req_done), .req_supported(req_supported),
    .halt_cmd_valid(halt_cmd_valid), .halt_cmd_set(halt_cmd_set), .halt_cmd_ep(halt_cmd_ep),
    .in_data_ready(in_data_ready), .out_buf_free(out_buf_free),
    .hs_valid(hs_valid), .hs_ready(hs_ready), .hs_code(hs_code)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit [NUM_EP-1:0] m_halt = '0;
  bit m_ps = 0, m_v = 0;
  bit [1:0] m_code = 0;
  string m_why = "R1";

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit [1:0] expect_code(bit [1:0] pid, int ep, output string why);
    bit st = m_halt[ep] || (ep == 0 && m_ps);
    case (pid)
      2'd0: begin why = "R2"; return 2'd1; end
      2'd1: begin why = st ? (m_halt[ep] ? "R5" : "R4") : "R8";
                  return st ? 2'd3 : (in_data_ready[ep] ? 2'd0 : 2'd2); end
      2'd2: begin why = st ? (m_halt[ep] ? "R5" : "R4") : "R9";
                  return st ? 2'd3 : (out_buf_free[ep] ? 2'd1 : 2'd2); end
      default: begin why = "R10"; return 2'd0; end
    endcase
  endfunction

  // Inputs are already set for this cycle; check, advance model, cross the edge.
  task automatic tick(string ph);
    bit fire;
    bit [1:0] c;
    string w;
    #1;
    chk({ph, " R11 tok_ready"}, tok_ready, (!m_v || hs_ready));
    fire = tok_valid && (!m_v || hs_ready);
    if (fire) c = expect_code(tok_pid, int'(tok_ep), w);
    if (m_v && hs_ready) m_v = 0;
    if (fire) begin m_v = 1; m_code = c; m_why = w; end
    if (bus_reset) begin m_halt = '0; m_ps = 0; end
    else begin
      if (halt_cmd_valid && halt_cmd_ep != 0) m_halt[halt_cmd_ep] = halt_cmd_set;
      if (fire && tok_pid == 0 && tok_ep == 0) m_ps = 0;
      if (req_done && !req_supported) m_ps = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk({ph, " R12 hs_valid"}, hs_valid, m_v);
    if (m_v) chk({ph, " ", m_why, " hs_code"}, hs_code, m_code);
  endtask

  task automatic idle();
    tok_valid = 0; req_done = 0; halt_cmd_valid = 0; bus_reset = 0; hs_ready = 1;
  endtask

  task automatic tok(bit [1:0] pid, int ep, string ph);
    idle(); tok_valid = 1; tok_pid = pid; tok_ep = EPW'(ep); tick(ph);
  endtask

  task automatic hcmd(bit set, int ep, string ph);
    idle(); halt_cmd_valid = 1; halt_cmd_set = set; halt_cmd_ep = EPW'(ep); tick(ph);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    hs_ready = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 hs_valid", hs_valid, 0);
    chk("R1 tok_ready", tok_ready, 1);
    rst_n = 1;
    @(negedge clk);
    in_data_ready = '1; out_buf_free = '1;

    // R1: no endpoint stalled after reset
    for (int e = 0; e < NUM_EP; e++) tok(2'd2, e, "R1");
    // R6: halt to endpoint 0 ignored
    hcmd(1, 0, "R6");
    tok(2'd2, 0, "R6");
    tok(2'd1, 0, "R6");
    // R5 halt set/clear, R2 SETUP on halted endpoint
    hcmd(1, 3, "R5");
    tok(2'd1, 3, "R5");
    tok(2'd0, 3, "R2");
    tok(2'd2, 3, "R5");
    hcmd(0, 3, "R5");
    tok(2'd2, 3, "R5");
    // R3/R4 protocol stall
    idle(); req_done = 1; req_supported = 0; tick("R3");
    tok(2'd2, 0, "R4");
    tok(2'd1, 0, "R4");
    tok(2'd0, 0, "R3");
    tok(2'd1, 0, "R3");
    // R3: SETUP and unsupported report on the same edge, flag set
    idle(); tok_valid = 1; tok_pid = 0; tok_ep = 0; req_done = 1; req_supported = 0; tick("R3");
    tok(2'd2, 0, "R3");
    // R7: bus reset clears both
    hcmd(1, 5, "R7");
    idle(); bus_reset = 1; tick("R7");
    tok(2'd2, 5, "R7");
    tok(2'd1, 0, "R7");
    // R12: command on same edge as token affects only later tokens
    idle(); tok_valid = 1; tok_pid = 2; tok_ep = 2;
    halt_cmd_valid = 1; halt_cmd_set = 1; halt_cmd_ep = 2; tick("R12");
    tok(2'd2, 2, "R12");
    // R8/R9 NAK paths
    in_data_ready = '0; out_buf_free = '0;
    tok(2'd1, 4, "R8");
    tok(2'd2, 4, "R9");
    // R10 reserved
    tok(2'd3, 1, "R10");
    // R11 back-pressure: slot held
    idle(); tok_valid = 1; tok_pid = 2; tok_ep = 4; hs_ready = 0; tick("R11");
    idle(); tok_valid = 1; tok_pid = 0; tok_ep = 1; hs_ready = 0; tick("R11");
    idle(); tok_valid = 1; tok_pid = 0; tok_ep = 1; hs_ready = 0; tick("R11");
    idle(); tok_valid = 1; tok_pid = 0; tok_ep = 1; hs_ready = 1; tick("R11");
    idle(); tick("R11");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      if (!(tok_valid && !(!m_v || hs_ready))) begin
        tok_valid = ($urandom % 10) < 7;
        tok_pid = 2'($urandom % 4);
        tok_ep = EPW'($urandom % NUM_EP);
        in_data_ready = NUM_EP'($urandom);
        out_buf_free = NUM_EP'($urandom);
      end
      req_done = ($urandom % 10) == 0;
      req_supported = ($urandom % 2) == 0;
      halt_cmd_valid = ($urandom % 8) == 0;
      halt_cmd_set = ($urandom % 2) == 0;
      halt_cmd_ep = EPW'($urandom % NUM_EP);
      bus_reset = ($urandom % 100) == 0;
      hs_ready = ($urandom % 10) < 7;
      tick("RND");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule